// File: doc/BRIEF.md
# Shifted Second-Operand Generator

This block builds the second source operand of a data-processing instruction, together with the carry bit that the shift or rotate produces. It has two forms. In the register form, a 32-bit register value is shifted or rotated in one of five ways. The amount comes either from a 5-bit field in the instruction or from the low byte of another register. In the immediate form, an 8-bit constant is rotated right by twice a 4-bit field. The incoming carry flag feeds the 33-bit rotate and is passed through wherever a case leaves the carry unchanged.

The unit is one pipeline stage of the operand path. Each request marked by `in_valid` is registered, and the result appears on `operand` and `carry_out` one clock later, with `out_valid` high. The registered outputs keep their values while no request arrives. The ALU that consumes the operand and the storage for the flags sit outside this block.

No state sequencing is involved. The stage has two conditions. Holding: `in_valid` is low and the register keeps its value. Loading: `in_valid` is high and the register takes the new result. Reset puts the register into the holding condition with zero contents.

Top module: `bsh_operand_unit`

## Requirements
- R1: While reset is asserted and after it is released, `operand`, `carry_out` and `out_valid` are all zero until the first accepted request.
- R2: A request with `in_valid` high appears on the outputs at the next rising edge, with `out_valid` high. A cycle with `in_valid` low drives `out_valid` low and leaves `operand` and `carry_out` unchanged.
- R3: Shift kind 2'b00 is logical left. Vacated bits fill with zeros. For an amount n in 1..31 the carry is source bit 32-n.
- R4: Shift kind 2'b01 is logical right. Vacated bits fill with zeros. For n in 1..31 the carry is source bit n-1.
- R5: Shift kind 2'b10 is arithmetic right. Vacated bits copy bit 31. For n in 1..31 the carry is bit n-1. For a register amount of 32 or more, every result bit and the carry equal bit 31.
- R6: Shift kind 2'b11 is rotate right. Bits leaving bit 0 re-enter at bit 31, and the carry is the last bit rotated out. A nonzero register amount that is a multiple of 32 returns the source unchanged, with carry equal to bit 31.
- R7: Rotate right with an instruction-field amount of 0 is the 33-bit rotate. The result is {carry_in, src[31:1]} and the carry is src[0].
- R8: With an instruction-field amount, left shift by 0 passes the source and carry_in through. Logical right and arithmetic right by 0 act as shifts by 32.
- R9: A register-supplied amount uses only bits [7:0] of `amt_reg`. A value of 0 passes the source through with carry_in, for every shift kind.
- R10: A register amount of exactly 32 for left or logical right shift gives 0, with carry equal to src[0] (left) or src[31] (right). An amount above 32 gives 0 with carry 0.
- R11: The immediate form gives the 8-bit value, zero-extended, rotated right by 2*rot4. The carry is result bit 31 when rot4 is nonzero, and carry_in when rot4 is 0.
- R12: In the immediate form, `src_val`, `shift_kind` and all amount inputs have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| use_imm | input | 1 | 1 selects the rotated-immediate form |
| imm8 | input | 8 | Immediate constant |
| rot4 | input | 4 | Immediate rotate field, rotation = 2*rot4 |
| src_val | input | 32 | Register value to shift |
| shift_kind | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amt_reg_sel | input | 1 | 1 takes the amount from amt_reg[7:0], 0 from amt_imm |
| amt_imm | input | 5 | Amount from the instruction field |
| amt_reg | input | 32 | Register supplying the amount (low byte used) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registered this cycle |
| operand | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The hardest cases to reach are the register-supplied amounts near and beyond the word width: exactly 32, 33, multiples of 32 for rotate, and values whose upper 24 bits are non-zero but whose low byte is zero. Uniform random amounts seldom land on these. The stimulus therefore includes a directed case for each of them. Its random phase also draws a quarter of the register amounts from the band 28..40, with noise in the upper bytes. Idle cycles are mixed in with changing inputs, so that a stage that does not hold its output would show up.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_LSL  = 3'd1,
        OP_LSR  = 3'd2,
        OP_ASR  = 3'd3,
        OP_ROR  = 3'd4,
        OP_RRX  = 3'd5
    } shift_op_e;

    typedef struct packed {
        shift_op_e        op;
        logic [CNT_W-1:0] amt;
    } shift_cmd_t;

endpackage

// File: rtl/bsh_amt_decode.sv
module bsh_amt_decode
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SAMT_W = 5
) (
    input  logic [1:0]       kind,
    input  logic             amt_reg_sel,
    input  logic [SAMT_W-1:0] amt_imm,
    input  logic [CNT_W-1:0] amt_reg_byte,
    output shift_cmd_t       cmd
);
    localparam logic [CNT_W-1:0] FULL_AMT = CNT_W'(DATA_W);

    logic [CNT_W-1:0] n;
    logic             n_zero;
    shift_kind_e      k;

    always_comb begin
        k      = shift_kind_e'(kind);
        n      = amt_reg_sel ? amt_reg_byte : CNT_W'(amt_imm);
        n_zero = (n == '0);
        cmd.amt = n;
        cmd.op  = OP_PASS;
        unique case (k)
            SK_LSL: cmd.op = n_zero ? OP_PASS : OP_LSL;
            SK_LSR: begin
                if (n_zero && !amt_reg_sel) begin
                    cmd.op  = OP_LSR;
                    cmd.amt = FULL_AMT;
                end else begin
                    cmd.op = n_zero ? OP_PASS : OP_LSR;
                end
            end
            SK_ASR: begin
                if (n_zero && !amt_reg_sel) begin
                    cmd.op  = OP_ASR;
                    cmd.amt = FULL_AMT;
                end else begin
                    cmd.op = n_zero ? OP_PASS : OP_ASR;
                end
            end
            SK_ROR: begin
                if (n_zero && !amt_reg_sel) cmd.op = OP_RRX;
                else cmd.op = n_zero ? OP_PASS : OP_ROR;
            end
            default: cmd.op = OP_PASS;
        endcase
    end
endmodule

// File: rtl/bsh_core.sv
module bsh_core
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] val,
    input  logic              cin,
    input  shift_cmd_t        cmd,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] FULL_AMT = CNT_W'(DATA_W);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_m1;
    logic [IDX_W-1:0] idx_neg;
    logic             in_range;

    always_comb begin
        idx      = cmd.amt[IDX_W-1:0];
        idx_m1   = idx - 1'b1;
        idx_neg  = ~idx + 1'b1;
        in_range = (cmd.amt < FULL_AMT);
        res      = val;
        cout     = cin;
        unique case (cmd.op)
            OP_PASS: begin
                res  = val;
                cout = cin;
            end
            OP_LSL: begin
                if (in_range) begin
                    res  = val << idx;
                    cout = val[idx_neg];
                end else if (cmd.amt == FULL_AMT) begin
                    res  = '0;
                    cout = val[0];
                end else begin
                    res  = '0;
                    cout = 1'b0;
                end
            end
            OP_LSR: begin
                if (in_range) begin
                    res  = val >> idx;
                    cout = val[idx_m1];
                end else if (cmd.amt == FULL_AMT) begin
                    res  = '0;
                    cout = val[DATA_W-1];
                end else begin
                    res  = '0;
                    cout = 1'b0;
                end
            end
            OP_ASR: begin
                if (in_range) begin
                    res  = DATA_W'($signed(val) >>> idx);
                    cout = val[idx_m1];
                end else begin
                    res  = {DATA_W{val[DATA_W-1]}};
                    cout = val[DATA_W-1];
                end
            end
            OP_ROR: begin
                if (idx == '0) begin
                    res  = val;
                    cout = val[DATA_W-1];
                end else begin
                    res  = (val >> idx) | (val << idx_neg);
                    cout = val[idx_m1];
                end
            end
            OP_RRX: begin
                res  = {cin, val[DATA_W-1:1]};
                cout = val[0];
            end
            default: begin
                res  = val;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/bsh_imm_rot.sv
module bsh_imm_rot #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] ext;
    logic [IDX_W-1:0]  ra;
    logic [IDX_W-1:0]  ra_neg;

    always_comb begin
        ext    = DATA_W'(imm);
        ra     = IDX_W'({rot, 1'b0});
        ra_neg = ~ra + 1'b1;
        if (ra == '0) res = ext;
        else          res = (ext >> ra) | (ext << ra_neg);
        cout = (rot != '0) ? res[DATA_W-1] : cin;
    end
endmodule

// File: rtl/bsh_operand_unit.sv
module bsh_operand_unit
    import bsh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    parameter int SAMT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm8,
    input  logic [ROT_W-1:0]  rot4,
    input  logic [DATA_W-1:0] src_val,
    input  logic [1:0]        shift_kind,
    input  logic              amt_reg_sel,
    input  logic [SAMT_W-1:0] amt_imm,
    input  logic [DATA_W-1:0] amt_reg,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] operand,
    output logic              carry_out
);
    shift_cmd_t        cmd;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic [DATA_W-1:0] im_res;
    logic              im_c;
    logic [DATA_W-1:0] nxt_res;
    logic              nxt_c;

    bsh_amt_decode #(.DATA_W(DATA_W), .SAMT_W(SAMT_W)) u_dec (
        .kind         (shift_kind),
        .amt_reg_sel  (amt_reg_sel),
        .amt_imm      (amt_imm),
        .amt_reg_byte (amt_reg[CNT_W-1:0]),
        .cmd          (cmd)
    );

    bsh_core #(.DATA_W(DATA_W)) u_core (
        .val  (src_val),
        .cin  (carry_in),
        .cmd  (cmd),
        .res  (sh_res),
        .cout (sh_c)
    );

    bsh_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
        .imm  (imm8),
        .rot  (rot4),
        .cin  (carry_in),
        .res  (im_res),
        .cout (im_c)
    );

    always_comb begin
        nxt_res = use_imm ? im_res : sh_res;
        nxt_c   = use_imm ? im_c   : sh_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            operand   <= '0;
            carry_out <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                operand   <= nxt_res;
                carry_out <= nxt_c;
            end
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(operand) && $stable(carry_out)));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_rrx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_imm && !amt_reg_sel && shift_kind == 2'b11 && amt_imm == '0)
        |=> (operand[DATA_W-1] == $past(carry_in) && carry_out == $past(src_val[0])));

    p_asr_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_imm && amt_reg_sel && shift_kind == 2'b10 &&
         amt_reg[CNT_W-1:0] >= CNT_W'(DATA_W))
        |=> (operand == {DATA_W{$past(src_val[DATA_W-1])}} &&
             carry_out == $past(src_val[DATA_W-1])));

    p_beyond_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_imm && amt_reg_sel && !shift_kind[1] &&
         amt_reg[CNT_W-1:0] > CNT_W'(DATA_W))
        |=> (operand == '0 && !carry_out));

    p_imm_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && use_imm && rot4 == '0)
        |=> (carry_out == $past(carry_in) && operand == DATA_W'($past(imm8))));

    p_regzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_imm && amt_reg_sel && amt_reg[CNT_W-1:0] == '0)
        |=> (operand == $past(src_val) && carry_out == $past(carry_in)));

endmodule

// File: tb/bsh_operand_unit_tb.sv
module bsh_operand_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        use_imm = 1'b0;
    logic [7:0]  imm8 = '0;
    logic [3:0]  rot4 = '0;
    logic [31:0] src_val = '0;
    logic [1:0]  shift_kind = '0;
    logic        amt_reg_sel = 1'b0;
    logic [4:0]  amt_imm = '0;
    logic [31:0] amt_reg = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] operand;
    logic        carry_out;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_op = '0;
    logic        exp_c  = 1'b0;
    logic        exp_v  = 1'b0;

    always #4 clk = ~clk;

    bsh_operand_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_imm(use_imm),
        .imm8(imm8), .rot4(rot4), .src_val(src_val), .shift_kind(shift_kind),
        .amt_reg_sel(amt_reg_sel), .amt_imm(amt_imm), .amt_reg(amt_reg),
        .carry_in(carry_in), .out_valid(out_valid), .operand(operand),
        .carry_out(carry_out)
    );

    // Behavioural model: one bit position per loop pass.
    task automatic model(output logic [31:0] r, output logic c);
        int n;
        r = src_val;
        c = carry_in;
        if (use_imm) begin
            r = {24'd0, imm8};
            for (int i = 0; i < 2 * rot4; i++) r = {r[0], r[31:1]};
            c = (rot4 != 0) ? r[31] : carry_in;
            return;
        end
        n = amt_reg_sel ? int'(amt_reg[7:0]) : int'(amt_imm);
        if (!amt_reg_sel && n == 0) begin
            if (shift_kind == 2'b11) begin
                c = src_val[0];
                r = {carry_in, src_val[31:1]};
                return;
            end
            if (shift_kind != 2'b00) n = 32;
        end
        for (int i = 0; i < n; i++) begin
            case (shift_kind)
                2'b00: begin c = r[31]; r = {r[30:0], 1'b0}; end
                2'b01: begin c = r[0];  r = {1'b0, r[31:1]}; end
                2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin c = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
    endtask

    task automatic compare(input string tag);
        n_cmp++;
        if (operand !== exp_op || carry_out !== exp_c || out_valid !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got op=%h c=%b v=%b, expected op=%h c=%b v=%b",
                     tag, operand, carry_out, out_valid, exp_op, exp_c, exp_v);
        end
    endtask

    task automatic step(input logic v, input logic ui, input logic [7:0] i8,
                        input logic [3:0] r4, input logic [31:0] sv,
                        input logic [1:0] k, input logic ars, input logic [4:0] ai,
                        input logic [31:0] ar, input logic ci, input string tag);
        logic [31:0] r;
        logic        c;
        @(negedge clk);
        in_valid = v; use_imm = ui; imm8 = i8; rot4 = r4; src_val = sv;
        shift_kind = k; amt_reg_sel = ars; amt_imm = ai; amt_reg = ar; carry_in = ci;
        model(r, c);
        @(posedge clk);
        if (v) begin exp_op = r; exp_c = c; end
        exp_v = v;
        #2;
        compare(tag);
    endtask

    function automatic string tag_of(logic v, logic ui, logic [1:0] k, logic ars,
                                     logic [4:0] ai, logic [7:0] ab);
        if (!v) return "R2";
        if (ui) return "R11";
        if (ars && ab == 0) return "R9";
        if (ars && ab >= 32 && k != 2'b11) return (k == 2'b10) ? "R5" : "R10";
        if (!ars && ai == 0) return (k == 2'b11) ? "R7" : "R8";
        case (k)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin : watchdog
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #2;
        compare("R1 reset");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 8'h00, 4'h0, 32'hDEAD_BEEF, 2'b00, 1'b0, 5'd3, 32'h0, 1'b1, "R1 idle after reset");
        // R3 left shifts
        step(1, 0, 8'h00, 4'h0, 32'h8000_0001, 2'b00, 0, 5'd4, 32'h0, 0, "R3");
        step(1, 0, 8'h00, 4'h0, 32'h4000_0000, 2'b00, 0, 5'd2, 32'h0, 0, "R3 carry");
        // R2 hold with changing inputs
        step(0, 1, 8'hFF, 4'h3, 32'h1234_5678, 2'b10, 1, 5'd9, 32'h5, 1, "R2 hold");
        // R4 and R8 immediate zero meaning 32
        step(1, 0, 8'h00, 4'h0, 32'hF000_000F, 2'b01, 0, 5'd3, 32'h0, 0, "R4");
        step(1, 0, 8'h00, 4'h0, 32'h8000_0000, 2'b01, 0, 5'd0, 32'h0, 0, "R8 lsr 0=32");
        step(1, 0, 8'h00, 4'h0, 32'h8000_0000, 2'b10, 0, 5'd0, 32'h0, 0, "R8 asr 0=32");
        step(1, 0, 8'h00, 4'h0, 32'hA5A5_0000, 2'b00, 0, 5'd0, 32'h0, 1, "R8 lsl 0 pass");
        // R5 arithmetic right
        step(1, 0, 8'h00, 4'h0, 32'h8000_0010, 2'b10, 0, 5'd5, 32'h0, 0, "R5");
        step(1, 0, 8'h00, 4'h0, 32'h7FFF_FFFF, 2'b10, 1, 5'd0, 32'd200, 1, "R5 reg 200");
        step(1, 0, 8'h00, 4'h0, 32'h9000_0000, 2'b10, 1, 5'd0, 32'd32, 0, "R5 reg 32");
        // R6 rotate right
        step(1, 0, 8'h00, 4'h0, 32'h0000_00F1, 2'b11, 0, 5'd8, 32'h0, 0, "R6");
        step(1, 0, 8'h00, 4'h0, 32'h8000_0001, 2'b11, 1, 5'd0, 32'd32, 0, "R6 reg 32");
        step(1, 0, 8'h00, 4'h0, 32'h0000_0008, 2'b11, 1, 5'd0, 32'd36, 0, "R6 reg 36");
        // R7 33-bit rotate
        step(1, 0, 8'h00, 4'h0, 32'h0000_0003, 2'b11, 0, 5'd0, 32'h0, 1, "R7 cin1");
        step(1, 0, 8'h00, 4'h0, 32'hFFFF_FFFE, 2'b11, 0, 5'd0, 32'h0, 0, "R7 cin0");
        // R9 register amount low byte only
        step(1, 0, 8'h00, 4'h0, 32'h1357_9BDF, 2'b01, 1, 5'd7, 32'h0000_0100, 1, "R9 byte zero");
        step(1, 0, 8'h00, 4'h0, 32'h1357_9BDF, 2'b11, 1, 5'd7, 32'h0, 0, "R9 ror zero");
        step(1, 0, 8'h00, 4'h0, 32'h1357_9BDF, 2'b00, 1, 5'd0, 32'hFFFF_FF05, 0, "R9 upper ignored");
        // R10 at and beyond the width
        step(1, 0, 8'h00, 4'h0, 32'h0000_0001, 2'b00, 1, 5'd0, 32'd32, 0, "R10 lsl 32");
        step(1, 0, 8'h00, 4'h0, 32'h8000_0000, 2'b01, 1, 5'd0, 32'd32, 0, "R10 lsr 32");
        step(1, 0, 8'h00, 4'h0, 32'hFFFF_FFFF, 2'b00, 1, 5'd0, 32'd33, 1, "R10 lsl 33");
        step(1, 0, 8'h00, 4'h0, 32'hFFFF_FFFF, 2'b01, 1, 5'd0, 32'd255, 1, "R10 lsr 255");
        // R11 immediate form
        step(1, 1, 8'hFF, 4'h1, 32'h0, 2'b00, 0, 5'd0, 32'h0, 0, "R11 rot1");
        step(1, 1, 8'h3C, 4'h0, 32'h0, 2'b00, 0, 5'd0, 32'h0, 1, "R11 rot0 cin");
        step(1, 1, 8'h01, 4'hF, 32'h0, 2'b00, 0, 5'd0, 32'h0, 1, "R11 rot15");
        // R12 immediate ignores register path
        step(1, 1, 8'h81, 4'h4, 32'hFFFF_FFFF, 2'b11, 1, 5'd31, 32'd40, 0, "R12 junk");
        step(1, 1, 8'h81, 4'h4, 32'h0000_0000, 2'b10, 0, 5'd0, 32'd0, 0, "R12 junk2");
        for (int i = 0; i < 3000; i++) begin
            logic        v, ui, ars, ci;
            logic [1:0]  k;
            logic [4:0]  ai;
            logic [7:0]  ab;
            logic [31:0] ar;
            v   = ($urandom % 5) != 0;
            ui  = ($urandom % 4) == 0;
            ars = ($urandom % 2) == 1;
            ci  = ($urandom % 2) == 1;
            k   = 2'($urandom);
            ai  = ($urandom % 6 == 0) ? 5'd0 : 5'($urandom);
            ab  = ($urandom % 4 == 0) ? 8'(28 + $urandom % 13) : 8'($urandom);
            ar  = {24'($urandom), ab};
            step(v, ui, 8'($urandom), 4'($urandom), $urandom, k, ars, ai, ar, ci,
                 tag_of(v, ui, k, ars, ai, ab));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule